// File: doc/BRIEF.md
# Descriptor Ring Pointer Manager

This block tracks the current descriptor position in two circular descriptor rings kept in host memory, one for transmit and one for receive. Each ring is one contiguous region. A configuration load, accepted only while the block is stopped, sets the region's start address and its entry count. The entry count is clamped to a legal power of two. Each descriptor describes one buffer, so a frame that spans several buffers simply uses consecutive descriptors. The DMA engine raises a one-cycle advance strobe per ring each time it finishes with a descriptor. The block then steps that ring's index and presents the memory address of the new current descriptor.

A small run controller has three states: stopped, running and suspended. Starting from the stopped state returns both rings to their first entry, so a stop followed by a start behaves as a fresh restart. Suspending and resuming leave both positions where they were, and processing picks up at the same descriptors. Advance strobes are honoured only while running.

Top module: `ring_ptr_mgr`

## Requirements
- R1: After reset the block is stopped (running_o=0, suspended_o=0), both indices are 0 and both descriptor addresses are 0.
- R2: A pulse on cfg_load_i while stopped stores both ring start addresses and clamped sizes and sets both indices to 0; a pulse while running or suspended changes nothing.
- R3: An entry count of 0 gives 1 entry, counts above 512 give 512, and any other count is rounded to the nearest power of two, with a count exactly between two powers going to the larger one.
- R4: An accepted advance strobe moves that ring's index up by one, and an index of size-1 goes to 0.
- R5: Each descriptor address equals start address + index * DESC_BYTES (16 by default), taken modulo 2^ADDR_W.
- R6: The two rings are independent: a strobe on one ring never changes the other ring's index or address.
- R7: Advance strobes are ignored while stopped or suspended, and also in a cycle where stop_i is high.
- R8: start_i while stopped (with stop_i low) enters running and sets both indices to 0 on the next cycle; start_i in any other state has no effect.
- R9: stop_i enters the stopped state from any state on the next cycle and takes priority over start_i and suspend_i; the indices keep their values.
- R10: While running, a high suspend_i enters suspended. While suspended, a low suspend_i returns to running. Both indices keep their values across the round trip.
- R11: running_o and suspended_o are never high together; both low means stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load_i | input | 1 | Load ring configuration (stopped state only) |
| tx_base_i | input | ADDR_W | Transmit ring start address |
| tx_count_i | input | CNT_W | Requested transmit entry count |
| rx_base_i | input | ADDR_W | Receive ring start address |
| rx_count_i | input | CNT_W | Requested receive entry count |
| start_i | input | 1 | Start request |
| stop_i | input | 1 | Stop request |
| suspend_i | input | 1 | Suspend request level |
| tx_adv_i | input | 1 | Transmit descriptor done strobe |
| rx_adv_i | input | 1 | Receive descriptor done strobe |
| tx_idx_o | output | IDX_W | Current transmit index |
| rx_idx_o | output | IDX_W | Current receive index |
| tx_desc_addr_o | output | ADDR_W | Current transmit descriptor address |
| rx_desc_addr_o | output | ADDR_W | Current receive descriptor address |
| running_o | output | 1 | Running state |
| suspended_o | output | 1 | Suspended state |

## Verification
The hardest cases to reach are the wrap points of the larger clamped sizes. To see where an odd count was rounded, the index must be walked all the way to its last entry and one step past it. The bench sweeps every count from 0 to 40 and a set of counts near the large-size boundaries. For each count it holds the advance strobe for exactly the expected size minus one cycles, then checks the index, the address and the wrap to zero. Stop, start and suspend are then mixed with strobes and configuration loads, so that ignored strobes and kept positions show up at the index ports.

// File: rtl/ring_ptr_pkg.sv
package ring_ptr_pkg;
  typedef enum logic [1:0] {
    RS_STOP = 2'd0,
    RS_RUN  = 2'd1,
    RS_SUSP = 2'd2
  } run_state_t;
endpackage

// File: rtl/ring_size_clamp.sv
// Converts a requested entry count into log2 of the legal ring size.
module ring_size_clamp #(
  parameter int CNT_W   = 10,
  parameter int LOG_MAX = 9,
  parameter int LOG_W   = 4
) (
  input  logic [CNT_W-1:0] count_i,
  output logic [LOG_W-1:0] log2_o
);
  int msb;
  int lg;
  logic half;

  always_comb begin
    msb  = 0;
    half = 1'b0;
    for (int i = 1; i < CNT_W; i++) begin
      if (count_i[i]) begin
        msb  = i;
        half = count_i[i-1];
      end
    end
    lg = half ? msb + 1 : msb;
    if (lg > LOG_MAX) lg = LOG_MAX;
    log2_o = LOG_W'(lg);
  end
endmodule

// File: rtl/ring_run_ctrl.sv
// Stopped / running / suspended controller for both rings.
module ring_run_ctrl
  import ring_ptr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic       suspend_i,
  input  logic       cfg_load_i,
  output run_state_t state_o,
  output logic       restart_o,
  output logic       cfg_we_o,
  output logic       accept_o
);
  run_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      RS_STOP: if (start_i && !stop_i) state_d = RS_RUN;
      RS_RUN: begin
        if (stop_i)         state_d = RS_STOP;
        else if (suspend_i) state_d = RS_SUSP;
      end
      RS_SUSP: begin
        if (stop_i)          state_d = RS_STOP;
        else if (!suspend_i) state_d = RS_RUN;
      end
      default: state_d = RS_STOP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= RS_STOP;
    else        state_q <= state_d;
  end

  assign state_o   = state_q;
  assign restart_o = (state_q == RS_STOP) && start_i && !stop_i;
  assign cfg_we_o  = (state_q == RS_STOP) && cfg_load_i;
  assign accept_o  = (state_q == RS_RUN) && !stop_i;
endmodule

// File: rtl/ring_slot.sv
// Per-ring configuration, index register and address generation.
module ring_slot #(
  parameter int ADDR_W     = 32,
  parameter int IDX_W      = 9,
  parameter int LOG_W      = 4,
  parameter int DESC_SHIFT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [LOG_W-1:0]  log2_i,
  input  logic              clear_i,
  input  logic              adv_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic [LOG_W-1:0]  log2_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] base_q;
  logic [LOG_W-1:0]  log2_q;
  logic [IDX_W-1:0]  idx_q, idx_d, mask;
  logic              idx_en;

  assign mask   = IDX_W'((32'd1 << log2_q) - 32'd1);
  assign idx_en = cfg_we_i | clear_i | adv_i;

  always_comb begin
    idx_d = idx_q;
    if (cfg_we_i || clear_i) idx_d = '0;
    else if (adv_i)          idx_d = (idx_q + 1'b1) & mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      log2_q <= '0;
    end else if (cfg_we_i) begin
      base_q <= base_i;
      log2_q <= log2_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (idx_en) idx_q <= idx_d;
  end

  assign idx_o  = idx_q;
  assign log2_o = log2_q;
  assign addr_o = base_q + (ADDR_W'(idx_q) << DESC_SHIFT);
endmodule

// File: rtl/ring_ptr_mgr.sv
module ring_ptr_mgr
  import ring_ptr_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 10,
  parameter int LOG_MAX    = 9,
  parameter int DESC_BYTES = 16,
  parameter int IDX_W      = LOG_MAX
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_load_i,
  input  logic [ADDR_W-1:0] tx_base_i,
  input  logic [CNT_W-1:0]  tx_count_i,
  input  logic [ADDR_W-1:0] rx_base_i,
  input  logic [CNT_W-1:0]  rx_count_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              suspend_i,
  input  logic              tx_adv_i,
  input  logic              rx_adv_i,
  output logic [IDX_W-1:0]  tx_idx_o,
  output logic [IDX_W-1:0]  rx_idx_o,
  output logic [ADDR_W-1:0] tx_desc_addr_o,
  output logic [ADDR_W-1:0] rx_desc_addr_o,
  output logic              running_o,
  output logic              suspended_o
);
  localparam int LOG_W      = $clog2(LOG_MAX + 1);
  localparam int DESC_SHIFT = $clog2(DESC_BYTES);
  localparam int NRING      = 2;

  run_state_t        state;
  logic              restart, cfg_we, accept;
  logic [ADDR_W-1:0] base_a [NRING];
  logic [CNT_W-1:0]  cnt_a  [NRING];
  logic              adv_a  [NRING];
  logic [LOG_W-1:0]  clog_a [NRING];
  logic [LOG_W-1:0]  slog_a [NRING];
  logic [IDX_W-1:0]  idx_a  [NRING];
  logic [ADDR_W-1:0] addr_a [NRING];
  logic [LOG_W-1:0]  tx_log2_q, rx_log2_q;

  ring_run_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
    .suspend_i(suspend_i), .cfg_load_i(cfg_load_i), .state_o(state),
    .restart_o(restart), .cfg_we_o(cfg_we), .accept_o(accept)
  );

  assign base_a[0] = tx_base_i;
  assign base_a[1] = rx_base_i;
  assign cnt_a[0]  = tx_count_i;
  assign cnt_a[1]  = rx_count_i;
  assign adv_a[0]  = tx_adv_i & accept;
  assign adv_a[1]  = rx_adv_i & accept;

  for (genvar g = 0; g < NRING; g++) begin : g_ring
    ring_size_clamp #(.CNT_W(CNT_W), .LOG_MAX(LOG_MAX), .LOG_W(LOG_W)) u_clamp (
      .count_i(cnt_a[g]), .log2_o(clog_a[g])
    );
    ring_slot #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .LOG_W(LOG_W),
                .DESC_SHIFT(DESC_SHIFT)) u_slot (
      .clk(clk), .rst_n(rst_n), .cfg_we_i(cfg_we), .base_i(base_a[g]),
      .log2_i(clog_a[g]), .clear_i(restart), .adv_i(adv_a[g]),
      .idx_o(idx_a[g]), .log2_o(slog_a[g]), .addr_o(addr_a[g])
    );
  end

  assign tx_idx_o       = idx_a[0];
  assign rx_idx_o       = idx_a[1];
  assign tx_desc_addr_o = addr_a[0];
  assign rx_desc_addr_o = addr_a[1];
  assign tx_log2_q      = slog_a[0];
  assign rx_log2_q      = slog_a[1];
  assign running_o      = (state == RS_RUN);
  assign suspended_o    = (state == RS_SUSP);
endmodule

// File: rtl/ring_ptr_mgr_chk.sv
module ring_ptr_mgr_chk #(
  parameter int IDX_W = 9,
  parameter int LOG_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             stop_i,
  input logic             suspend_i,
  input logic             cfg_load_i,
  input logic             tx_adv_i,
  input logic             running_o,
  input logic             suspended_o,
  input logic [IDX_W-1:0] tx_idx_o,
  input logic [IDX_W-1:0] rx_idx_o,
  input logic [LOG_W-1:0] tx_log2,
  input logic [LOG_W-1:0] rx_log2
);
  p_states_exclusive_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(running_o && suspended_o));

  p_tx_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    32'(tx_idx_o) < (32'd1 << tx_log2));

  p_rx_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    32'(rx_idx_o) < (32'd1 << rx_log2));

  p_tx_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (running_o && !stop_i && tx_adv_i && tx_log2 != '0) |=> (tx_idx_o != $past(tx_idx_o)));

  p_restart_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!running_o && !suspended_o && start_i && !stop_i)
      |=> (running_o && tx_idx_o == '0 && rx_idx_o == '0));

  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!running_o && !start_i && !cfg_load_i) |=> ($stable(tx_idx_o) && $stable(rx_idx_o)));

  p_stop_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> (!running_o && !suspended_o));

  p_resume_keeps_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (suspended_o && !suspend_i && !stop_i)
      |=> (running_o && $stable(tx_idx_o) && $stable(rx_idx_o)));
endmodule

bind ring_ptr_mgr ring_ptr_mgr_chk #(.IDX_W(IDX_W), .LOG_W(LOG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
  .suspend_i(suspend_i), .cfg_load_i(cfg_load_i), .tx_adv_i(tx_adv_i),
  .running_o(running_o), .suspended_o(suspended_o), .tx_idx_o(tx_idx_o),
  .rx_idx_o(rx_idx_o), .tx_log2(tx_log2_q), .rx_log2(rx_log2_q)
);

// File: tb/test_ring_ptr_mgr.sv
module test_ring_ptr_mgr;
  localparam int ADDR_W = 32;
  localparam int CNT_W  = 10;
  localparam int IDX_W  = 9;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              cfg_load_i, start_i, stop_i, suspend_i, tx_adv_i, rx_adv_i;
  logic [ADDR_W-1:0] tx_base_i, rx_base_i;
  logic [CNT_W-1:0]  tx_count_i, rx_count_i;
  logic [IDX_W-1:0]  tx_idx_o, rx_idx_o;
  logic [ADDR_W-1:0] tx_desc_addr_o, rx_desc_addr_o;
  logic              running_o, suspended_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  ring_ptr_mgr i_ring_ptr_mgr (
    .clk(clk), .rst_n(rst_n), .cfg_load_i(cfg_load_i), .tx_base_i(tx_base_i),
    .tx_count_i(tx_count_i), .rx_base_i(rx_base_i), .rx_count_i(rx_count_i),
    .start_i(start_i), .stop_i(stop_i), .suspend_i(suspend_i),
    .tx_adv_i(tx_adv_i), .rx_adv_i(rx_adv_i), .tx_idx_o(tx_idx_o),
    .rx_idx_o(rx_idx_o), .tx_desc_addr_o(tx_desc_addr_o),
    .rx_desc_addr_o(rx_desc_addr_o), .running_o(running_o),
    .suspended_o(suspended_o)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic int exp_size(input int c);
    int best = 1;
    for (int p = 1; p <= 512; p = p * 2) begin
      int d  = (c > p) ? c - p : p - c;
      int bd = (c > best) ? c - best : best - c;
      if (d <= bd) best = p;
    end
    return best;
  endfunction

  task automatic pulse_stop();
    stop_i = 1'b1; step(); stop_i = 1'b0;
  endtask

  task automatic pulse_start();
    start_i = 1'b1; step(); start_i = 1'b0;
  endtask

  task automatic load(input logic [31:0] tb, input int tc, input logic [31:0] rb, input int rc);
    tx_base_i = tb; tx_count_i = CNT_W'(tc);
    rx_base_i = rb; rx_count_i = CNT_W'(rc);
    cfg_load_i = 1'b1; step(); cfg_load_i = 1'b0;
  endtask

  task automatic sweep_one(input int c);
    int s = exp_size(c);
    logic [31:0] tb = 32'h1000_0000;
    pulse_stop();
    load(tb, c, 32'h2000_0040, 5);
    pulse_start();
    chk("R8 start index", 32'(tx_idx_o), 0);
    tx_adv_i = 1'b1;
    repeat (s - 1) step();
    tx_adv_i = 1'b0;
    step();
    chk($sformatf("R3 last index count=%0d", c), 32'(tx_idx_o), 32'(s - 1));
    chk("R5 last address", tx_desc_addr_o, tb + 32'((s - 1) * 16));
    chk("R6 rx untouched", 32'(rx_idx_o), 0);
    tx_adv_i = 1'b1; step(); tx_adv_i = 1'b0;
    chk($sformatf("R4 wrap count=%0d", c), 32'(tx_idx_o), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int big [13] = '{63, 64, 95, 96, 97, 255, 384, 511, 512, 513, 767, 768, 1023};
    rst_n = 1'b0;
    cfg_load_i = 1'b0; start_i = 1'b0; stop_i = 1'b0; suspend_i = 1'b0;
    tx_adv_i = 1'b0; rx_adv_i = 1'b0;
    tx_base_i = '0; rx_base_i = '0; tx_count_i = '0; rx_count_i = '0;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R1 reset state
    chk("R1 running", 32'(running_o), 0);
    chk("R1 suspended", 32'(suspended_o), 0);
    chk("R1 tx index", 32'(tx_idx_o), 0);
    chk("R1 rx index", 32'(rx_idx_o), 0);
    chk("R1 tx address", tx_desc_addr_o, 0);
    chk("R1 rx address", rx_desc_addr_o, 0);

    // R3 R4 R5 sweep over clamp sizes
    for (int c = 0; c <= 40; c++) sweep_one(c);
    foreach (big[k]) sweep_one(big[k]);

    // R6 receive ring alone, R2 load sets address
    pulse_stop();
    load(32'h3000_0000, 4, 32'h4000_0100, 8);
    chk("R2 rx address after load", rx_desc_addr_o, 32'h4000_0100);
    pulse_start();
    chk("R11 running", 32'(running_o), 1);
    rx_adv_i = 1'b1; repeat (3) step(); rx_adv_i = 1'b0;
    chk("R6 rx index", 32'(rx_idx_o), 3);
    chk("R5 rx address", rx_desc_addr_o, 32'h4000_0130);
    chk("R6 tx index", 32'(tx_idx_o), 0);

    // R9 stop holds indices, R7 advances ignored while stopped
    stop_i = 1'b1; rx_adv_i = 1'b1; step(); stop_i = 1'b0;
    chk("R9 stopped", 32'(running_o), 0);
    chk("R7 stop-cycle advance", 32'(rx_idx_o), 3);
    tx_adv_i = 1'b1; repeat (4) step(); tx_adv_i = 1'b0; rx_adv_i = 1'b0;
    chk("R7 rx stopped", 32'(rx_idx_o), 3);
    chk("R7 tx stopped", 32'(tx_idx_o), 0);

    // R8 restart reloads both rings
    pulse_start();
    chk("R8 rx restart", 32'(rx_idx_o), 0);
    tx_adv_i = 1'b1; rx_adv_i = 1'b1; repeat (2) step();
    tx_adv_i = 1'b0; rx_adv_i = 1'b0;
    chk("R4 tx two steps", 32'(tx_idx_o), 2);

    // R10 suspend keeps position
    suspend_i = 1'b1; step();
    chk("R10 suspended", 32'(suspended_o), 1);
    chk("R11 not running", 32'(running_o), 0);
    tx_adv_i = 1'b1; rx_adv_i = 1'b1; repeat (4) step();
    tx_adv_i = 1'b0; rx_adv_i = 1'b0;
    chk("R7 tx suspended", 32'(tx_idx_o), 2);
    chk("R7 rx suspended", 32'(rx_idx_o), 2);
    load(32'h5000_0000, 2, 32'h6000_0000, 2);
    chk("R2 load ignored suspended", tx_desc_addr_o, 32'h3000_0020);
    pulse_start();
    chk("R8 start ignored suspended", 32'(tx_idx_o), 2);
    suspend_i = 1'b0; step();
    chk("R10 resumed", 32'(running_o), 1);
    chk("R10 tx kept", 32'(tx_idx_o), 2);
    chk("R10 rx kept", 32'(rx_idx_o), 2);
    tx_adv_i = 1'b1; step(); tx_adv_i = 1'b0;
    chk("R10 continues", 32'(tx_idx_o), 3);

    // R8 start while running ignored; R2 load while running ignored
    pulse_start();
    chk("R8 start ignored running", 32'(tx_idx_o), 3);
    load(32'h5000_0000, 2, 32'h6000_0000, 2);
    chk("R2 load ignored running", rx_desc_addr_o, 32'h4000_0120);

    // R9 stop beats start and suspend
    stop_i = 1'b1; start_i = 1'b1; suspend_i = 1'b1; step();
    stop_i = 1'b0; start_i = 1'b0; suspend_i = 1'b0;
    chk("R9 stop priority", 32'({running_o, suspended_o}), 0);
    chk("R9 tx held", 32'(tx_idx_o), 3);

    // R5 address wraps modulo 2^ADDR_W
    load(32'hFFFF_FFF0, 2, 32'h0, 1);
    pulse_start();
    tx_adv_i = 1'b1; step(); tx_adv_i = 1'b0;
    chk("R5 address wrap", tx_desc_addr_o, 32'h0000_0000);
    chk("R4 size one rx", 32'(rx_idx_o), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule